// File: doc/BRIEF.md
# Two-Class Priority Interrupt Arbiter

This block picks one interrupt line to service for each of two interrupt classes: a normal class and a fast class. It takes a vector of pending lines, a per-line mask, a per-line class-routing bit and a per-line priority value. A separate arbiter serves each class. When the arbiter for a class is armed and at least one line of that class is eligible, it finds the most urgent eligible line. It then registers that line's number as the class code, raises the class request and disarms.

After that, the request and the code stay frozen, whatever happens to the pending lines. They change only when software issues a renew strobe for that class. The renew strobe drops the request and re-arms the arbiter, and arbitration runs again on the following cycle.

A global mask input blocks all new grants while it is high. Line capture and the register bus sit outside the block. The block only takes level inputs and one-cycle strobes and presents the two requests with their codes. No interface here moves data, so there is no valid/ready handshake and no back-pressure.

Top module: `intc_prio_arbiter`

## Requirements
- R1: Reset behaviour. While `rst_n` is low and after it is released, `irq_o` and `fiq_o` are 0, `irq_code_o` and `fiq_code_o` are 0, and both arbiters are armed.
- R2: Eligibility. Line k counts for the normal class only if `pend_i[k]`=1, `mask_i[k]`=0 (1 means masked) and `route_fiq_i[k]`=0. Line k counts for the fast class only if `pend_i[k]`=1, `mask_i[k]`=0 and `route_fiq_i[k]`=1.
- R3: Urgency. The priority of line k is `prio_i[k*PRIO_W +: PRIO_W]`. Value 0 is the most urgent. An eligible line with a smaller value always wins over one with a larger value.
- R4: Ties. Among eligible lines that share the most urgent value, the line with the highest index wins.
- R5: Grant timing. Suppose an armed arbiter sees an eligible line and the global mask is low during a cycle. At the next rising edge, the request goes to 1, the code takes the winner's index, and the arbiter disarms.
- R6: Freeze. While a request is 1 and no renew strobe for its class is seen, the request stays 1 and the code stays unchanged, whatever pending, mask, routing or priority changes occur.
- R7: Renew. A cycle with the class renew strobe high drops that class's request to 0 at the next edge and re-arms the arbiter. If an eligible line exists in the following cycle, the request rises again one edge later, carrying the newly computed winner.
- R8: Global mask. In any cycle where `gmask_i` is 1, neither request may rise at the next edge. The arbiter stays armed and grants on the first edge after `gmask_i` returns to 0.
- R9: Class independence. A renew strobe for one class leaves the other class's request and code untouched.
- R10: No candidate. An armed arbiter with no eligible line keeps its request at 0 and keeps its previous code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | NUM_LINES | Pending level per line |
| mask_i | input | NUM_LINES | Per-line mask, 1 = masked |
| route_fiq_i | input | NUM_LINES | Per-line class: 0 normal, 1 fast |
| prio_i | input | NUM_LINES*PRIO_W | Per-line priority, line k at bits k*PRIO_W upward |
| gmask_i | input | 1 | Global mask, blocks new grants in both classes |
| irq_renew_i | input | 1 | One-cycle renew strobe, normal class |
| fiq_renew_i | input | 1 | One-cycle renew strobe, fast class |
| irq_o | output | 1 | Normal-class request |
| irq_code_o | output | $clog2(NUM_LINES) | Latched winning line, normal class |
| fiq_o | output | 1 | Fast-class request |
| fiq_code_o | output | $clog2(NUM_LINES) | Latched winning line, fast class |

## Verification
The bench builds the block with NUM_LINES=8 and PRIO_W=3. With only eight priority levels and eight lines, the cases that matter are easy to set up by hand: ties at an equal value, the top line winning a tie, a masked winner handing the grant to the next line, and lines split between the two classes. The same scan logic elaborates unchanged at the default 32 lines. The bound checker covers the freeze, renew, global-mask and winner-ranking rules on every cycle of every scenario.

// File: rtl/intc_arb_pkg.sv
package intc_arb_pkg;
  // class selectors used for the per-class generate
  localparam int CLS_NORMAL = 0;
  localparam int CLS_FAST   = 1;
  localparam int NUM_CLASSES = 2;
endpackage

// File: rtl/intc_prio_scan.sv
module intc_prio_scan #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 5,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]        elig_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  output logic                        found_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic [PRIO_W-1:0] best;

  // Ascending scan; "<=" lets a later (higher) index take an equal value.
  always_comb begin
    found_o = 1'b0;
    best    = '1;
    idx_o   = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (elig_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] <= best)) begin
        found_o = 1'b1;
        best    = prio_i[i*PRIO_W +: PRIO_W];
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_class_arb.sv
module intc_class_arb #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 5,
  parameter int CLS       = 0,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        pend_i,
  input  logic [NUM_LINES-1:0]        mask_i,
  input  logic [NUM_LINES-1:0]        route_fiq_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  input  logic                        gmask_i,
  input  logic                        renew_i,
  output logic                        req_o,
  output logic [IDX_W-1:0]            code_o
);
  logic [NUM_LINES-1:0] route_match;
  logic [NUM_LINES-1:0] elig;
  logic                 found;
  logic [IDX_W-1:0]     win_idx;

  generate
    if (CLS == intc_arb_pkg::CLS_FAST) begin : g_fast
      assign route_match = route_fiq_i;
    end else begin : g_normal
      assign route_match = ~route_fiq_i;
    end
  endgenerate

  assign elig = pend_i & ~mask_i & route_match;

  intc_prio_scan #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_scan (
    .elig_i (elig),
    .prio_i (prio_i),
    .found_o(found),
    .idx_o  (win_idx)
  );

  // The armed flag is the inverse of the request: one register per class.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_o  <= 1'b0;
      code_o <= '0;
    end else if (renew_i) begin
      req_o  <= 1'b0;
    end else if (!req_o && found && !gmask_i) begin
      req_o  <= 1'b1;
      code_o <= win_idx;
    end
  end
endmodule

// File: rtl/intc_prio_arbiter.sv
module intc_prio_arbiter #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 5,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        pend_i,
  input  logic [NUM_LINES-1:0]        mask_i,
  input  logic [NUM_LINES-1:0]        route_fiq_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  input  logic                        gmask_i,
  input  logic                        irq_renew_i,
  input  logic                        fiq_renew_i,
  output logic                        irq_o,
  output logic [IDX_W-1:0]            irq_code_o,
  output logic                        fiq_o,
  output logic [IDX_W-1:0]            fiq_code_o
);
  localparam int NC = intc_arb_pkg::NUM_CLASSES;

  logic [NC-1:0]   renew;
  logic [NC-1:0]   req;
  logic [IDX_W-1:0] code [NC];

  assign renew[intc_arb_pkg::CLS_NORMAL] = irq_renew_i;
  assign renew[intc_arb_pkg::CLS_FAST]   = fiq_renew_i;

  generate
    for (genvar c = 0; c < NC; c++) begin : g_cls
      intc_class_arb #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .CLS(c)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend_i),
        .mask_i     (mask_i),
        .route_fiq_i(route_fiq_i),
        .prio_i     (prio_i),
        .gmask_i    (gmask_i),
        .renew_i    (renew[c]),
        .req_o      (req[c]),
        .code_o     (code[c])
      );
    end
  endgenerate

  assign irq_o      = req[intc_arb_pkg::CLS_NORMAL];
  assign irq_code_o = code[intc_arb_pkg::CLS_NORMAL];
  assign fiq_o      = req[intc_arb_pkg::CLS_FAST];
  assign fiq_code_o = code[intc_arb_pkg::CLS_FAST];
endmodule

// File: rtl/intc_prio_arbiter_chk.sv
module intc_prio_arbiter_chk #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 5,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_LINES-1:0]        pend_i,
  input logic [NUM_LINES-1:0]        mask_i,
  input logic [NUM_LINES-1:0]        route_fiq_i,
  input logic [NUM_LINES*PRIO_W-1:0] prio_i,
  input logic                        gmask_i,
  input logic                        irq_renew_i,
  input logic                        fiq_renew_i,
  input logic                        irq_o,
  input logic [IDX_W-1:0]            irq_code_o,
  input logic                        fiq_o,
  input logic [IDX_W-1:0]            fiq_code_o
);
  logic [NUM_LINES-1:0]        n_elig_q, f_elig_q;
  logic [NUM_LINES*PRIO_W-1:0] prio_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_elig_q <= '0;
      f_elig_q <= '0;
      prio_q   <= '0;
    end else begin
      n_elig_q <= pend_i & ~mask_i & ~route_fiq_i;
      f_elig_q <= pend_i & ~mask_i & route_fiq_i;
      prio_q   <= prio_i;
    end
  end

  // true if some eligible line should have beaten line w
  function automatic logic outranked(input logic [NUM_LINES-1:0] e,
                                     input logic [NUM_LINES*PRIO_W-1:0] p,
                                     input logic [IDX_W-1:0] w);
    logic r;
    logic [PRIO_W-1:0] pw;
    r  = 1'b0;
    pw = p[w*PRIO_W +: PRIO_W];
    for (int j = 0; j < NUM_LINES; j++) begin
      if (e[j] && (p[j*PRIO_W +: PRIO_W] < pw ||
                   (p[j*PRIO_W +: PRIO_W] == pw && IDX_W'(j) > w)))
        r = 1'b1;
    end
    return r;
  endfunction

  logic n_bad, f_bad, n_in, f_in;
  always_comb begin
    n_bad = outranked(n_elig_q, prio_q, irq_code_o);
    f_bad = outranked(f_elig_q, prio_q, fiq_code_o);
    n_in  = n_elig_q[irq_code_o];
    f_in  = f_elig_q[fiq_code_o];
  end

  // R2
  irq_winner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> n_in);
  // R2
  fiq_winner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> f_in);
  // R3
  irq_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !n_bad);
  // R4
  fiq_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> !f_bad);
  // R6
  irq_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_renew_i) |=> (irq_o && $stable(irq_code_o)));
  // R6
  fiq_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && !fiq_renew_i) |=> (fiq_o && $stable(fiq_code_o)));
  // R7
  irq_renew_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_renew_i |=> !irq_o);
  // R7
  fiq_renew_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_renew_i |=> !fiq_o);
  // R8
  gmask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_i |=> (!$rose(irq_o) && !$rose(fiq_o)));
  // R10
  irq_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !$rose(irq_o)) |-> $stable(irq_code_o));
endmodule

bind intc_prio_arbiter intc_prio_arbiter_chk #(
  .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .mask_i(mask_i),
  .route_fiq_i(route_fiq_i), .prio_i(prio_i), .gmask_i(gmask_i),
  .irq_renew_i(irq_renew_i), .fiq_renew_i(fiq_renew_i),
  .irq_o(irq_o), .irq_code_o(irq_code_o), .fiq_o(fiq_o), .fiq_code_o(fiq_code_o)
);

// File: tb/intc_prio_arbiter_bench.sv
module intc_prio_arbiter_bench;
  localparam int NL = 8;
  localparam int PW = 3;
  localparam int IW = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] pend = '0, mask = '0, route = '0;
  logic [NL*PW-1:0] prio = '0;
  logic          gmask = 1'b0, irq_renew = 1'b0, fiq_renew = 1'b0;
  logic          irq_o, fiq_o;
  logic [IW-1:0] irq_code, fiq_code;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intc_prio_arbiter #(.NUM_LINES(NL), .PRIO_W(PW)) u_intc_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .route_fiq_i(route),
    .prio_i(prio), .gmask_i(gmask), .irq_renew_i(irq_renew), .fiq_renew_i(fiq_renew),
    .irq_o(irq_o), .irq_code_o(irq_code), .fiq_o(fiq_o), .fiq_code_o(fiq_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance one cycle; inputs change and outputs are read at falling edges
  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_prio(input int line, input int v);
    prio[line*PW +: PW] = PW'(v);
  endtask

  // return both classes to armed with nothing pending
  task automatic quiesce();
    pend = '0; mask = '0; route = '0; prio = '0; gmask = 1'b0;
    irq_renew = 1'b1; fiq_renew = 1'b1;
    step();
    irq_renew = 1'b0; fiq_renew = 1'b0;
    step();
  endtask

  task automatic t_reset();
    chk("R1 irq_o", int'(irq_o), 0);
    chk("R1 fiq_o", int'(fiq_o), 0);
    chk("R1 irq_code", int'(irq_code), 0);
    chk("R1 fiq_code", int'(fiq_code), 0);
  endtask

  task automatic t_priority();
    quiesce();
    set_prio(2, 3); set_prio(5, 1); set_prio(6, 4);
    pend = 8'b0110_0100;
    step();
    chk("R5 irq_o after one edge", int'(irq_o), 1);
    chk("R3 smaller value wins", int'(irq_code), 5);
  endtask

  task automatic t_hold_renew();
    // continues from t_priority: code 5 granted
    set_prio(6, 0); pend[7] = 1'b1; set_prio(7, 0);
    step(); step();
    chk("R6 request held", int'(irq_o), 1);
    chk("R6 code frozen", int'(irq_code), 5);
    irq_renew = 1'b1;
    step();
    irq_renew = 1'b0;
    chk("R7 request dropped", int'(irq_o), 0);
    step();
    chk("R7 request re-raised", int'(irq_o), 1);
    chk("R7 new winner", int'(irq_code), 7);
  endtask

  task automatic t_tie_mask();
    quiesce();
    set_prio(0, 2); set_prio(1, 2); set_prio(3, 2); set_prio(7, 2);
    pend = 8'b1000_1011;
    step();
    chk("R4 tie to highest index", int'(irq_code), 7);
    mask[7] = 1'b1;
    irq_renew = 1'b1; step(); irq_renew = 1'b0; step();
    chk("R2 masked line skipped", int'(irq_code), 3);
  endtask

  task automatic t_route_indep();
    quiesce();
    set_prio(4, 0); set_prio(1, 5);
    route[4] = 1'b1;
    pend = 8'b0001_0010;
    step();
    chk("R2 normal class code", int'(irq_code), 1);
    chk("R2 fast class code", int'(fiq_code), 4);
    chk("R2 fast request", int'(fiq_o), 1);
    irq_renew = 1'b1; pend[1] = 1'b0;
    step();
    irq_renew = 1'b0;
    chk("R9 fast request untouched", int'(fiq_o), 1);
    chk("R9 fast code untouched", int'(fiq_code), 4);
    step();
    chk("R10 no candidate keeps low", int'(irq_o), 0);
    chk("R10 code kept", int'(irq_code), 1);
  endtask

  task automatic t_gmask();
    quiesce();
    gmask = 1'b1;
    set_prio(3, 6);
    pend[3] = 1'b1;
    step(); step(); step();
    chk("R8 no grant under global mask", int'(irq_o), 0);
    gmask = 1'b0;
    step();
    chk("R8 grant after mask lifts", int'(irq_o), 1);
    chk("R8 code after mask lifts", int'(irq_code), 3);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_priority();
    t_hold_renew();
    t_tie_mask();
    t_route_indep();
    t_gmask();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule